// File: doc/BRIEF.md
# Timer Event Output Pin Generator

This block produces the level on a general purpose timer's external pin from two event strobes that the counter logic supplies: one for counter overflow and one for compare match. A small configuration register, loaded through a write strobe, selects which events act on the pin, whether an event flips the pin or produces a one-cycle pulse, the level the pin rests at when idle, and whether the pin is an output at all.

Counting and event detection stay outside. The block registers the pin level, so every effect shows on `pin_out` one clock after the cycle that caused it. When the pin is turned around to an input, the output enable goes low and the level register is frozen.

Top module: `tmr_evt_pin`

## Requirements
- R1: Reset, asynchronous and active low, sets `pin_out` to 0, clears the stored configuration (trigger mode 0, toggle off, default level 0, direction output) and so leaves `pin_oe` at 1.
- R2: Trigger mode `cfg_trig` encodes 0 as no trigger, 1 as overflow only, and 2 as overflow plus match. Value 3 behaves like 2.
- R3: A match strobe acts on the pin only in trigger modes 2 and 3. In mode 1 a match strobe alone leaves `pin_out` unchanged.
- R4: With toggle select 1, direction output, counter running and a nonzero mode, each cycle with a selected event inverts `pin_out` one clock later. A cycle where overflow and match come together inverts it once.
- R5: With toggle select 0 in the same conditions, `pin_out` one clock later equals the default level XOR the selected event, giving a one-cycle pulse opposite to the default level.
- R6: With direction output and either trigger mode 0 or `tmr_run` low, `pin_out` takes the stored default level one clock later, whatever the event strobes do.
- R7: With stored direction 1 (input), `pin_oe` is 0 and `pin_out` keeps its level whatever the events, run state or default level.
- R8: A cycle with `cfg_wr` high loads all four fields and ignores that cycle's events. If the written mode is 0 and the written direction is 0, `pin_out` takes the written default level one clock later. Otherwise `pin_out` keeps its level for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_trig | input | 2 | Trigger mode to write |
| cfg_toggle | input | 1 | 1 selects toggle, 0 selects pulse |
| cfg_dflt | input | 1 | Idle default level to write |
| cfg_dir | input | 1 | Pin direction to write: 0 output, 1 input |
| tmr_run | input | 1 | Counter is running |
| ovf_evt | input | 1 | Overflow event strobe, one cycle |
| mat_evt | input | 1 | Match event strobe, one cycle |
| pin_out | output | 1 | Registered pin level |
| pin_oe | output | 1 | Pin output enable |

## Verification
The properties assume that the event strobes and the configuration fields are synchronous to `clk` and settle before each rising edge. They also assume that the configuration fields matter only in cycles where `cfg_wr` is high, and that reset is held across at least one rising edge before the first write. The bench changes every input on the falling edge, one table row per cycle, and keeps all inputs at zero while reset is held. Rows cover overflow and match strobes arriving alone and together, and strobes that arrive during a write, while stopped, or while the pin is an input, so each guarded branch of the level logic is reached.

// File: rtl/tmr_evt_pin_pkg.sv
package tmr_evt_pin_pkg;

  localparam int TRIG_W = 2;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_OVF   = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_BOTH3 = 2'd3
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  toggle;
    logic  dflt;
    logic  dir_in;
  } pin_cfg_t;

  // Event gating by trigger mode: overflow in any nonzero mode, match only in 2/3.
  function automatic logic pick_event(trig_e t, logic ovf, logic mat);
    logic r;
    case (t)
      TRIG_NONE: r = 1'b0;
      TRIG_OVF:  r = ovf;
      default:   r = ovf | mat;
    endcase
    return r;
  endfunction

  // Steady-state next pin level when no configuration write is in progress.
  function automatic logic next_level(pin_cfg_t c, logic run, logic evt, logic cur);
    logic r;
    if (c.dir_in)
      r = cur;
    else if (c.trig == TRIG_NONE || !run)
      r = c.dflt;
    else if (c.toggle)
      r = cur ^ evt;
    else
      r = c.dflt ^ evt;
    return r;
  endfunction

  // Next pin level in a write cycle.
  function automatic logic write_level(pin_cfg_t w, logic cur);
    return (w.trig == TRIG_NONE && !w.dir_in) ? w.dflt : cur;
  endfunction

endpackage

// File: rtl/tmr_evt_pin_cfg.sv
module tmr_evt_pin_cfg
  import tmr_evt_pin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  pin_cfg_t wr_cfg,
  output pin_cfg_t cfg_q
);

  localparam pin_cfg_t CFG_RST = '{trig: TRIG_NONE, toggle: 1'b0, dflt: 1'b0, dir_in: 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= CFG_RST;
    else if (wr)
      cfg_q <= wr_cfg;
  end

endmodule

// File: rtl/tmr_evt_pin_sel.sv
module tmr_evt_pin_sel
  import tmr_evt_pin_pkg::*;
#(
  parameter bit MATCH_TRIG_EN = 1'b1
) (
  input  trig_e trig,
  input  logic  ovf,
  input  logic  mat,
  output logic  sel_evt
);

  generate
    if (MATCH_TRIG_EN) begin : g_with_match
      assign sel_evt = pick_event(trig, ovf, mat);
    end else begin : g_ovf_only
      logic unused_mat;
      assign unused_mat = mat;
      assign sel_evt    = (trig != TRIG_NONE) && ovf;
    end
  endgenerate

endmodule

// File: rtl/tmr_evt_pin_lvl.sv
module tmr_evt_pin_lvl
  import tmr_evt_pin_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  pin_cfg_t wr_cfg,
  input  pin_cfg_t cfg_q,
  input  logic     run,
  input  logic     sel_evt,
  output logic     pin_q
);

  logic pin_d;

  always_comb begin
    if (wr)
      pin_d = write_level(wr_cfg, pin_q);
    else
      pin_d = next_level(cfg_q, run, sel_evt, pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pin_q <= 1'b0;
    else
      pin_q <= pin_d;
  end

endmodule

// File: rtl/tmr_evt_pin.sv
module tmr_evt_pin
  import tmr_evt_pin_pkg::*;
#(
  parameter bit MATCH_TRIG_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [TRIG_W-1:0] cfg_trig,
  input  logic              cfg_toggle,
  input  logic              cfg_dflt,
  input  logic              cfg_dir,
  input  logic              tmr_run,
  input  logic              ovf_evt,
  input  logic              mat_evt,
  output logic              pin_out,
  output logic              pin_oe
);

  pin_cfg_t          wr_cfg;
  pin_cfg_t          cfg_q;
  logic              sel_evt;
  logic [TRIG_W-1:0] cur_trig;
  logic              cur_toggle;
  logic              cur_dflt;
  logic              cur_dir;

  assign wr_cfg = '{trig: trig_e'(cfg_trig), toggle: cfg_toggle, dflt: cfg_dflt, dir_in: cfg_dir};

  assign cur_trig   = cfg_q.trig;
  assign cur_toggle = cfg_q.toggle;
  assign cur_dflt   = cfg_q.dflt;
  assign cur_dir    = cfg_q.dir_in;

  tmr_evt_pin_cfg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cfg_wr),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  tmr_evt_pin_sel #(.MATCH_TRIG_EN(MATCH_TRIG_EN)) u_sel (
    .trig    (cfg_q.trig),
    .ovf     (ovf_evt),
    .mat     (mat_evt),
    .sel_evt (sel_evt)
  );

  tmr_evt_pin_lvl u_lvl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .wr_cfg  (wr_cfg),
    .cfg_q   (cfg_q),
    .run     (tmr_run),
    .sel_evt (sel_evt),
    .pin_q   (pin_out)
  );

  assign pin_oe = ~cfg_q.dir_in;

endmodule

// File: rtl/tmr_evt_pin_chk.sv
module tmr_evt_pin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [1:0] cfg_trig,
  input logic       cfg_toggle,
  input logic       cfg_dflt,
  input logic       cfg_dir,
  input logic       tmr_run,
  input logic       ovf_evt,
  input logic       mat_evt,
  input logic       pin_out,
  input logic       pin_oe,
  input logic [1:0] cur_trig,
  input logic       cur_toggle,
  input logic       cur_dflt,
  input logic       cur_dir,
  input logic       sel_evt
);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (pin_out == 1'b0 && pin_oe == 1'b1);
    end
  end

  assert_ovf_selects_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && cur_trig != 2'd0) |-> sel_evt);

  assert_match_mode1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_trig == 2'd1 && !ovf_evt) |-> !sel_evt);

  assert_match_mode2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_trig[1] && mat_evt) |-> sel_evt);

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !cur_dir && cur_trig != 2'd0 && tmr_run && cur_toggle)
    |=> (pin_out == ($past(pin_out) ^ $past(sel_evt))));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !cur_dir && cur_trig != 2'd0 && tmr_run && !cur_toggle)
    |=> (pin_out == ($past(cur_dflt) ^ $past(sel_evt))));

  assert_idle_default_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !cur_dir && (cur_trig == 2'd0 || !tmr_run))
    |=> (pin_out == $past(cur_dflt)));

  assert_input_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && cur_dir) |=> $stable(pin_out));

  assert_oe_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (pin_oe == !$past(cfg_dir)));

  assert_write_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_trig == 2'd0 && !cfg_dir) |=> (pin_out == $past(cfg_dflt)));

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && (cfg_trig != 2'd0 || cfg_dir)) |=> $stable(pin_out));

  assert_write_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cur_toggle == $past(cfg_toggle)));

endmodule

bind tmr_evt_pin tmr_evt_pin_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr     (cfg_wr),
  .cfg_trig   (cfg_trig),
  .cfg_toggle (cfg_toggle),
  .cfg_dflt   (cfg_dflt),
  .cfg_dir    (cfg_dir),
  .tmr_run    (tmr_run),
  .ovf_evt    (ovf_evt),
  .mat_evt    (mat_evt),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .cur_trig   (cur_trig),
  .cur_toggle (cur_toggle),
  .cur_dflt   (cur_dflt),
  .cur_dir    (cur_dir),
  .sel_evt    (sel_evt)
);

// File: tb/tmr_evt_pin_tb.sv
module tmr_evt_pin_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_trig = 2'd0;
  logic       cfg_toggle = 1'b0;
  logic       cfg_dflt = 1'b0;
  logic       cfg_dir = 1'b0;
  logic       tmr_run = 1'b0;
  logic       ovf_evt = 1'b0;
  logic       mat_evt = 1'b0;
  logic       pin_out;
  logic       pin_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tmr_evt_pin u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr     (cfg_wr),
    .cfg_trig   (cfg_trig),
    .cfg_toggle (cfg_toggle),
    .cfg_dflt   (cfg_dflt),
    .cfg_dir    (cfg_dir),
    .tmr_run    (tmr_run),
    .ovf_evt    (ovf_evt),
    .mat_evt    (mat_evt),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] trig;
    logic       tog;
    logic       dflt;
    logic       dir;
    logic       run;
    logic       ovf;
    logic       mat;
    logic       exp_pin;
    logic       exp_oe;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;

  // wr trig tog dflt dir run ovf mat | pin oe | requirement
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 write mode 1, pin held
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd4}, // R4 overflow flips
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3}, // R3 match ignored in mode 1
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 flips back
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4}, // R4 no event, hold
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd8}, // R8 match in write cycle ignored
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd2}, // R2 match acts in mode 2
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4}, // R4 both together, one flip
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6}, // R6 stopped, default 0
    '{1'b1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 write pulse mode, held
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 rests at default 1
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd5}, // R5 overflow pulse
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 pulse lasts one cycle
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5}, // R5 match pulse
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd5}, // R5 back to default
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 write mode 3, held
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd2}, // R2 mode 3 takes match
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 turn to input
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 overflow ignored
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 default ignored
    '{1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd8}, // R8 mode 0 write loads 1
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6}, // R6 mode 0 holds default
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8}, // R8 mode 0 write loads 0
    '{1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7}, // R7 input write, no load
    '{1'b1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd8}  // R8 output write loads 1
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive_idle();
    cfg_wr = 1'b0; cfg_trig = 2'd0; cfg_toggle = 1'b0; cfg_dflt = 1'b0;
    cfg_dir = 1'b0; tmr_run = 1'b0; ovf_evt = 1'b0; mat_evt = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "pin_out in reset", pin_out, 1'b0);
    check("R1", "pin_oe in reset", pin_oe, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cfg_wr     = VEC[i].wr;
      cfg_trig   = VEC[i].trig;
      cfg_toggle = VEC[i].tog;
      cfg_dflt   = VEC[i].dflt;
      cfg_dir    = VEC[i].dir;
      tmr_run    = VEC[i].run;
      ovf_evt    = VEC[i].ovf;
      mat_evt    = VEC[i].mat;
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i].req, i), "pin_out", pin_out, VEC[i].exp_pin);
      check($sformatf("R%0d row %0d", VEC[i].req, i), "pin_oe", pin_oe, VEC[i].exp_oe);
    end

    // R1: reset in the middle of operation, pin currently 1
    drive_idle();
    rst_n = 1'b0;
    #1;
    check("R1", "pin_out async reset", pin_out, 1'b0);
    check("R1", "pin_oe async reset", pin_oe, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: configuration cleared, so a running overflow leaves default 0
    tmr_run = 1'b1; ovf_evt = 1'b1;
    @(negedge clk);
    check("R1", "pin_out after reset with overflow", pin_out, 1'b0);

    // R5: pulse with default 0 gives a single high cycle
    drive_idle();
    cfg_wr = 1'b1; cfg_trig = 2'd1; tmr_run = 1'b1;
    @(negedge clk);
    drive_idle();
    tmr_run = 1'b1; ovf_evt = 1'b1;
    @(negedge clk);
    check("R5", "pulse high", pin_out, 1'b1);
    ovf_evt = 1'b0;
    @(negedge clk);
    check("R5", "pulse ends", pin_out, 1'b0);

    // R6: toggle mode, pin high, then stop -> default 0
    drive_idle();
    cfg_wr = 1'b1; cfg_trig = 2'd2; cfg_toggle = 1'b1; tmr_run = 1'b1;
    @(negedge clk);
    drive_idle();
    tmr_run = 1'b1; ovf_evt = 1'b1;
    @(negedge clk);
    check("R4", "toggle to 1", pin_out, 1'b1);
    drive_idle();
    ovf_evt = 1'b1;
    @(negedge clk);
    check("R6", "stopped returns to default", pin_out, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule